// File: doc/BRIEF.md
# DRAM Mode Register Command Decoder

This block models the device side of the mode-programming path in a double-data-rate DRAM. On every rising clock edge with clock enable high, it samples the command strobes, the two bank-select bits and the multiplexed address bus. It then decides whether a mode-set command has arrived, and whether that command targets the primary mode register or the extended one.

A legal write to the primary register updates these registered outputs:
- burst length
- burst ordering
- read latency
- test mode

It can also raise a one-cycle DLL reset pulse. A legal write to the extended register updates the DLL enable and the output drive selection.

A write is rejected in any of these cases:
- it carries a reserved code or a nonzero reserved bit;
- any bank is still open;
- it arrives inside the recovery window of the previous write.

A rejected write leaves the stored values unchanged and produces a one-cycle error pulse. A busy output marks the recovery window so that a controller model can hold off its next command.

Top module: `mode_reg_decoder`

## Requirements
- R1: A mode-set command is recognised only on a rising edge where cke_i is 1 and cs_ni, ras_ni, cas_ni and we_ni are all 0. With cs_ni high or cke_i low, the pins have no effect on any output.
- R2: A legal mode-set with ba_i[0]=0 writes the primary register, and the new values appear on the outputs right after that edge. Field encodings:
  - addr_i[2:0] is the burst length: 001→2, 010→4, 011→8, shown on burst_len_o as that number.
  - addr_i[3] is the burst ordering: 1 means interleaved.
  - addr_i[6:4] is the read latency: 011→3, 100→4, shown on cas_lat_o as that number.
- R3: A primary write with a reserved burst-length code or a reserved latency code is rejected. Rejection means err_o is 1 for the cycle after the edge and no stored field changes.
- R4: A primary write is rejected if any of these bits is nonzero: ba_i[1], addr_i[12:9], or addr_i[7] (addr_i[7] only while ALLOW_TEST_MODE=0). addr_i[8] is always allowed.
- R5: A legal mode-set with ba_i[0]=1 writes the extended register:
  - dll_en_o becomes the inverse of addr_i[0];
  - drive_sel_o becomes {addr_i[6], addr_i[1]}.
  The write is rejected if ba_i[1] or any of addr_i[12:7] and addr_i[5:2] is nonzero.
- R6: A mode-set while any bit of bank_idle_i is 0 is rejected.
- R7: After an accepted write, busy_o is 1 for MRD_CYCLES-1 cycles. Any command (cs_ni low and not all of ras_ni, cas_ni, we_ni high) sampled while busy_o is 1 is rejected. A mode-set sampled MRD_CYCLES edges after the write is accepted.
- R8: err_o is a single-cycle pulse per rejected command. It falls on the next cycle when no new rejection occurs.
- R9: mr_valid_o and emr_valid_o are 0 after reset. Each is set by the first accepted write to its register and then stays set.
- R10: dll_reset_o is 1 for exactly one cycle after an accepted primary write with addr_i[8]=1, and is otherwise 0.
- R11: During and after reset, all field outputs, busy_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable; commands are ignored when low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank select; bit 0 picks the extended register |
| addr_i | input | ADDR_W | Multiplexed address carrying the field codes |
| bank_idle_i | input | NUM_BANKS | One bit per bank, 1 when the bank is precharged |
| burst_len_o | output | 4 | Burst length in beats (2, 4 or 8; 0 before the first write) |
| burst_interleave_o | output | 1 | 1 for interleaved burst ordering |
| cas_lat_o | output | 3 | Read latency in clocks (3 or 4) |
| test_mode_o | output | 1 | Stored test-mode bit |
| dll_reset_o | output | 1 | One-cycle DLL reset pulse |
| dll_en_o | output | 1 | DLL enabled |
| drive_sel_o | output | 2 | Output drive selection {addr_i[6], addr_i[1]} |
| mr_valid_o | output | 1 | Primary register has been written legally |
| emr_valid_o | output | 1 | Extended register has been written legally |
| busy_o | output | 1 | Recovery window after an accepted write |
| err_o | output | 1 | Pulse for a rejected command |

## Verification
The assertions rely on bank_idle_i reporting the true bank state at the sampling edge. They also assume that the command pins, address and bank inputs are settled before each rising edge. The pulse-width and busy checks further assume MRD_CYCLES is at least 2. The bench meets these assumptions by changing every input only at the falling edge, and by changing bank_idle_i only between commands. It always returns the strobes to a no-operation pattern after each command, so no stray command reaches the decoder.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef struct packed {
    logic [3:0] burst_len;
    logic       interleave;
    logic [2:0] cas_lat;
    logic       test_mode;
  } mode_fields_t;

  typedef struct packed {
    logic       dll_en;
    logic [1:0] drive_sel;
  } ext_fields_t;

  // 0 marks a reserved code
  function automatic logic [3:0] decode_burst(input logic [2:0] code);
    case (code)
      3'b001:  decode_burst = 4'd2;
      3'b010:  decode_burst = 4'd4;
      3'b011:  decode_burst = 4'd8;
      default: decode_burst = 4'd0;
    endcase
  endfunction

  function automatic logic [2:0] decode_latency(input logic [2:0] code);
    case (code)
      3'b011:  decode_latency = 3'd3;
      3'b100:  decode_latency = 3'd4;
      default: decode_latency = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/mrd_cmd_decode.sv
module mrd_cmd_decode (
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output logic mode_set_o,
  output logic any_cmd_o
);
  logic selected;
  logic is_nop;

  assign selected   = cke_i & ~cs_ni;
  assign is_nop     = ras_ni & cas_ni & we_ni;
  assign any_cmd_o  = selected & ~is_nop;
  assign mode_set_o = selected & ~ras_ni & ~cas_ni & ~we_ni;
endmodule

// File: rtl/mrd_field_check.sv
module mrd_field_check
  import mrd_pkg::*;
#(
  parameter int ADDR_W          = 13,
  parameter bit ALLOW_TEST_MODE = 1'b0
) (
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mode_ok_o,
  output logic              ext_ok_o,
  output mode_fields_t      mode_f_o,
  output ext_fields_t       ext_f_o,
  output logic              dll_rst_req_o
);
  localparam int HI = ADDR_W - 1;

  logic       upper_clear;
  logic       tm_ok;
  logic       ext_clear;
  logic [3:0] bl;
  logic [2:0] cl;

  assign bl          = decode_burst(addr_i[2:0]);
  assign cl          = decode_latency(addr_i[6:4]);
  assign upper_clear = ~|addr_i[HI:9];

  generate
    if (ALLOW_TEST_MODE) begin : g_tm_on
      assign tm_ok = 1'b1;
    end else begin : g_tm_off
      assign tm_ok = ~addr_i[7];
    end
  endgenerate

  assign mode_ok_o = (bl != 4'd0) && (cl != 3'd0) && upper_clear && tm_ok && !ba_i[1];

  assign mode_f_o.burst_len  = bl;
  assign mode_f_o.interleave = addr_i[3];
  assign mode_f_o.cas_lat    = cl;
  assign mode_f_o.test_mode  = addr_i[7];
  assign dll_rst_req_o       = addr_i[8];

  assign ext_clear = ~|addr_i[HI:7] & ~|addr_i[5:2];
  assign ext_ok_o  = ext_clear && !ba_i[1];

  assign ext_f_o.dll_en    = ~addr_i[0];
  assign ext_f_o.drive_sel = {addr_i[6], addr_i[1]};
endmodule

// File: rtl/mrd_recovery_timer.sv
module mrd_recovery_timer #(
  parameter int MRD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int LOAD  = (MRD_CYCLES > 1) ? MRD_CYCLES - 1 : 0;
  localparam int CNT_W = (LOAD > 0) ? $clog2(LOAD + 1) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(LOAD);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mode_reg_decoder.sv
module mode_reg_decoder
  import mrd_pkg::*;
#(
  parameter int ADDR_W          = 13,
  parameter int NUM_BANKS       = 4,
  parameter int MRD_CYCLES      = 2,
  parameter bit ALLOW_TEST_MODE = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [1:0]           ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_BANKS-1:0] bank_idle_i,
  output logic [3:0]           burst_len_o,
  output logic                 burst_interleave_o,
  output logic [2:0]           cas_lat_o,
  output logic                 test_mode_o,
  output logic                 dll_reset_o,
  output logic                 dll_en_o,
  output logic [1:0]           drive_sel_o,
  output logic                 mr_valid_o,
  output logic                 emr_valid_o,
  output logic                 busy_o,
  output logic                 err_o
);
  logic         mode_set, any_cmd;
  logic         mode_ok, ext_ok, dll_rst_req;
  mode_fields_t mode_f, mode_q;
  ext_fields_t  ext_f, ext_q;
  logic         all_idle, busy;
  logic         take_mr, take_emr, reject;
  logic         mr_valid_q, emr_valid_q, err_q, dll_rst_q;

  mrd_cmd_decode u_cmd (
    .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .mode_set_o(mode_set), .any_cmd_o(any_cmd)
  );

  mrd_field_check #(.ADDR_W(ADDR_W), .ALLOW_TEST_MODE(ALLOW_TEST_MODE)) u_fields (
    .ba_i(ba_i), .addr_i(addr_i),
    .mode_ok_o(mode_ok), .ext_ok_o(ext_ok),
    .mode_f_o(mode_f), .ext_f_o(ext_f), .dll_rst_req_o(dll_rst_req)
  );

  mrd_recovery_timer #(.MRD_CYCLES(MRD_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(take_mr | take_emr), .busy_o(busy)
  );

  assign all_idle = &bank_idle_i;
  assign take_mr  = mode_set & ~busy & all_idle & ~ba_i[0] & mode_ok;
  assign take_emr = mode_set & ~busy & all_idle &  ba_i[0] & ext_ok;
  // busy rejects every command; otherwise only failed mode-sets
  assign reject   = (any_cmd & busy) | (mode_set & ~take_mr & ~take_emr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= '0;
      ext_q       <= '0;
      mr_valid_q  <= 1'b0;
      emr_valid_q <= 1'b0;
      err_q       <= 1'b0;
      dll_rst_q   <= 1'b0;
    end else begin
      err_q     <= reject;
      dll_rst_q <= take_mr & dll_rst_req;
      if (take_mr) begin
        mode_q     <= mode_f;
        mr_valid_q <= 1'b1;
      end
      if (take_emr) begin
        ext_q       <= ext_f;
        emr_valid_q <= 1'b1;
      end
    end
  end

  assign burst_len_o        = mode_q.burst_len;
  assign burst_interleave_o = mode_q.interleave;
  assign cas_lat_o          = mode_q.cas_lat;
  assign test_mode_o        = mode_q.test_mode;
  assign dll_reset_o        = dll_rst_q;
  assign dll_en_o           = ext_q.dll_en;
  assign drive_sel_o        = ext_q.drive_sel;
  assign mr_valid_o         = mr_valid_q;
  assign emr_valid_o        = emr_valid_q;
  assign busy_o             = busy;
  assign err_o              = err_q;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int NUM_BANKS  = 4,
  parameter int MRD_CYCLES = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cke_i,
  input logic                 cs_ni,
  input logic                 ras_ni,
  input logic                 cas_ni,
  input logic                 we_ni,
  input logic [NUM_BANKS-1:0] bank_idle_i,
  input logic [3:0]           burst_len_o,
  input logic [2:0]           cas_lat_o,
  input logic                 dll_reset_o,
  input logic                 dll_en_o,
  input logic [1:0]           drive_sel_o,
  input logic                 mr_valid_o,
  input logic                 emr_valid_o,
  input logic                 busy_o,
  input logic                 err_o
);
  localparam bit SHORT = (MRD_CYCLES < 2);

  p_bank_open_rejects_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && !cs_ni && !ras_ni && !cas_ni && !we_ni && !(&bank_idle_i)) |=> err_o);

  p_reject_keeps_fields_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(burst_len_o) && $stable(cas_lat_o) && $stable(dll_en_o) && $stable(drive_sel_o)));

  p_burst_code_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_valid_o |-> (burst_len_o == 4'd2 || burst_len_o == 4'd4 || burst_len_o == 4'd8));

  p_latency_code_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_valid_o |-> (cas_lat_o == 3'd3 || cas_lat_o == 3'd4));

  p_mr_valid_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_valid_o |=> mr_valid_o);

  p_emr_valid_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emr_valid_o |=> emr_valid_o);

  p_dll_reset_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |=> (SHORT || !dll_reset_o));

  p_busy_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |-> (SHORT || busy_o));
endmodule

bind mode_reg_decoder mrd_checker #(.NUM_BANKS(NUM_BANKS), .MRD_CYCLES(MRD_CYCLES)) u_mrd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
  .cas_ni(cas_ni), .we_ni(we_ni), .bank_idle_i(bank_idle_i),
  .burst_len_o(burst_len_o), .cas_lat_o(cas_lat_o), .dll_reset_o(dll_reset_o),
  .dll_en_o(dll_en_o), .drive_sel_o(drive_sel_o), .mr_valid_o(mr_valid_o),
  .emr_valid_o(emr_valid_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/mode_reg_decoder_test.sv
`timescale 1ns/1ps
module mode_reg_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  idle;
  logic [3:0]  burst_len;
  logic        inter, tm, dll_rst, dll_en, mr_v, emr_v, busy, err;
  logic [2:0]  cl;
  logic [1:0]  drv;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mode_reg_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .bank_idle_i(idle),
    .burst_len_o(burst_len), .burst_interleave_o(inter), .cas_lat_o(cl),
    .test_mode_o(tm), .dll_reset_o(dll_rst), .dll_en_o(dll_en), .drive_sel_o(drv),
    .mr_valid_o(mr_v), .emr_valid_o(emr_v), .busy_o(busy), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_nop();
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  // drive at falling edge, sample 1 ns after the rising edge
  task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                       input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(posedge clk);
    #1;
    drive_nop();
    ba = '0; addr = '0;
  endtask

  task automatic mrs(input logic [1:0] b, input logic [12:0] a);
    issue(1'b0, 1'b0, 1'b0, 1'b0, b, a);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R11 burst_len", burst_len, 0);
    chk("R11 cas_lat", cl, 0);
    chk("R11 busy", busy, 0);
    chk("R11 err", err, 0);
    chk("R11 dll_en", dll_en, 0);
    chk("R9 mr_valid reset", mr_v, 0);
    chk("R9 emr_valid reset", emr_v, 0);
  endtask

  task automatic t_ignored();
    issue(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 13'h032);
    chk("R1 cs high mr_valid", mr_v, 0);
    chk("R1 cs high err", err, 0);
    @(negedge clk); cke = 1'b0;
    mrs(2'b00, 13'h032);
    chk("R1 cke low mr_valid", mr_v, 0);
    chk("R1 cke low burst_len", burst_len, 0);
    chk("R1 cke low err", err, 0);
    @(negedge clk); cke = 1'b1;
    settle();
  endtask

  task automatic t_mode_write();
    mrs(2'b00, 13'h032);
    chk("R2 bl4", burst_len, 4);
    chk("R2 seq", inter, 0);
    chk("R2 cl3", cl, 3);
    chk("R9 mr_valid set", mr_v, 1);
    chk("R7 busy after write", busy, 1);
    chk("R2 no err", err, 0);
    next_cycle();
    chk("R7 busy ends", busy, 0);
    settle();
    mrs(2'b00, 13'h04B);
    chk("R2 bl8", burst_len, 8);
    chk("R2 interleave", inter, 1);
    chk("R2 cl4", cl, 4);
    settle();
    mrs(2'b00, 13'h031);
    chk("R2 bl2", burst_len, 2);
    chk("R2 cl3 again", cl, 3);
    settle();
  endtask

  task automatic t_reserved_codes();
    mrs(2'b00, 13'h030);
    chk("R3 bl 000 err", err, 1);
    chk("R3 bl kept", burst_len, 2);
    next_cycle();
    chk("R8 err falls", err, 0);
    mrs(2'b00, 13'h022);
    chk("R3 cl 010 err", err, 1);
    chk("R3 cl kept", cl, 3);
    settle();
    mrs(2'b00, 13'h034);
    chk("R3 bl 100 err", err, 1);
    settle();
  endtask

  task automatic t_reserved_bits();
    mrs(2'b00, 13'h232);
    chk("R4 a9 err", err, 1);
    chk("R4 a9 bl kept", burst_len, 2);
    settle();
    mrs(2'b00, 13'h0B2);
    chk("R4 a7 err", err, 1);
    chk("R4 test mode kept", tm, 0);
    settle();
    mrs(2'b10, 13'h032);
    chk("R4 ba1 err", err, 1);
    chk("R4 ba1 bl kept", burst_len, 2);
    settle();
  endtask

  task automatic t_ext();
    mrs(2'b01, 13'h000);
    chk("R5 dll on", dll_en, 1);
    chk("R5 drive 0", drv, 0);
    chk("R9 emr_valid set", emr_v, 1);
    chk("R5 mode untouched", burst_len, 2);
    settle();
    mrs(2'b01, 13'h043);
    chk("R5 dll off", dll_en, 0);
    chk("R5 drive 3", drv, 3);
    settle();
    mrs(2'b01, 13'h004);
    chk("R5 a2 err", err, 1);
    chk("R5 drive kept", drv, 3);
    settle();
    mrs(2'b11, 13'h000);
    chk("R5 ba1 err", err, 1);
    chk("R5 dll kept", dll_en, 0);
    settle();
  endtask

  task automatic t_bank_open();
    @(negedge clk); idle = 4'b1011;
    mrs(2'b00, 13'h04B);
    chk("R6 open bank err", err, 1);
    chk("R6 bl kept", burst_len, 2);
    @(negedge clk); idle = 4'b1111;
    settle();
  endtask

  task automatic t_recovery();
    mrs(2'b00, 13'h032);
    chk("R7 first accepted", burst_len, 4);
    mrs(2'b00, 13'h04B);
    chk("R7 second rejected err", err, 1);
    chk("R7 second rejected bl", burst_len, 4);
    settle();
    mrs(2'b00, 13'h031);
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 13'h000);
    chk("R7 activate during busy err", err, 1);
    chk("R7 bl after activate", burst_len, 2);
    settle();
    issue(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 13'h000);
    chk("R7 activate when free no err", err, 0);
    settle();
    mrs(2'b00, 13'h032);
    @(posedge clk);
    mrs(2'b00, 13'h04B);
    chk("R7 boundary accepted", burst_len, 8);
    chk("R7 boundary no err", err, 0);
    settle();
  endtask

  task automatic t_dll_reset();
    chk("R10 idle low", dll_rst, 0);
    mrs(2'b00, 13'h132);
    chk("R10 pulse high", dll_rst, 1);
    chk("R10 fields written", burst_len, 4);
    next_cycle();
    chk("R10 pulse low", dll_rst, 0);
    settle();
  endtask

  initial begin
    #250000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    cke = 1'b1; drive_nop(); ba = '0; addr = '0; idle = 4'b1111;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    next_cycle();
    t_reset();
    t_ignored();
    t_mode_write();
    t_reserved_codes();
    t_reserved_bits();
    t_ext();
    t_bank_open();
    t_recovery();
    t_dll_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule